// File: doc/BRIEF.md
# Receive Bit-Slip Aligner

This block takes parallel words from a receive stream of fixed width and re-frames them at any of the word's bit positions. It keeps the previous word next to the current one and selects a word-wide window out of the joined pair. The window position is the alignment offset, which is always visible on an output. User logic moves the window one bit per single-cycle slide pulse, leftward or rightward. In the automatic mode the block ignores the pulse, searches by itself for a configured alignment pattern and freezes once the pattern appears.

The behaviour is driven by one state machine. Its states are OFF (fixed alignment), READY (manual mode, accepting a pulse), SETTLE (one cycle after an accepted pulse), SEEK (automatic mode, comparing the output word with the pattern), WAIT (automatic mode, pausing after a slide) and LOCK (pattern found).

Its transitions are:
- **enter**: any mode change goes to the entry state of the new mode: OFF, READY or SEEK.
- **slide**: READY to SETTLE on a pulse.
- **settle**: SETTLE to READY.
- **miss**: SEEK to WAIT.
- **recheck**: WAIT to SEEK when the wait count expires.
- **hit**: SEEK to LOCK.

Top module: `rx_bitslip_aligner`

## Requirements
- R1: During and right after reset, `aligned_word` is 0, `bit_offset` is 0 and `seek_locked` is 0. The mode register starts in OFF.
- R2: In OFF mode (`slide_mode`=2'b00), `bit_offset` stays 0 and slide pulses are ignored. `aligned_word` equals the input word from two clock edges earlier.
- R3: At every clock edge, `aligned_word` is loaded with bits [2W-1-k -: W] of the pair {previous word, current word}, where the previous word is in the upper half and k is `bit_offset` before that edge.
- R4: In left mode (2'b01), an accepted pulse adds 1 to `bit_offset` at the next edge. The offset wraps from W-1 to 0.
- R5: In right mode (2'b10), an accepted pulse subtracts 1 from `bit_offset` at the next edge. The offset wraps from 0 to W-1.
- R6: A pulse in the cycle right after an accepted pulse is dropped, not queued.
- R7: In the cycle where `slide_mode` changes, any pulse is dropped. A change to OFF clears `bit_offset` to 0 at that edge.
- R8: In auto mode (2'b11), `slide_pulse` is ignored. In SEEK, if `aligned_word` differs from `seek_pattern`, the offset adds 1 (with wrap) and the block waits `seek_wait`+1 cycles before the next compare.
- R9: When `aligned_word` equals `seek_pattern` in SEEK, `seek_locked` rises at the next edge. It then holds, with the offset frozen, until the mode changes. Outside auto mode `seek_locked` is 0.
- R10: On entering auto mode from offset 0, with the pattern found at offset n and no other match earlier in the search, `seek_locked` rises n*(`seek_wait`+2)+1 edges after the edge that registered the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | W | Raw parallel receive word |
| slide_pulse | input | 1 | One-cycle request to move the alignment by one bit |
| slide_mode | input | 2 | 00 off, 01 left, 10 right, 11 auto |
| seek_wait | input | 4 | Cycles to wait after an automatic slide (0 to 15) |
| seek_pattern | input | W | Word searched for in auto mode |
| aligned_word | output | W | Realigned output word |
| bit_offset | output | clog2(W) | Current alignment offset |
| seek_locked | output | 1 | Pattern found in auto mode |

## Verification
The hardest behaviour to reach from the ports is the exact lock time in auto mode. It depends on the wait count, on the position of the pattern among the word's rotations, and on the register delay between an offset change and the output word. The stimulus holds a constant, aperiodic input word, so every window is a known rotation of it. It sets the pattern to the rotation at offset 3 and samples `seek_locked` on the edge before and the edge of the predicted lock, once for a wait of 7 and once for a wait of 0. Dropped pulses are reached by issuing pulses on consecutive cycles and in the same cycle as a mode change.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEFT  = 2'b01,
        MODE_RIGHT = 2'b10,
        MODE_AUTO  = 2'b11
    } slip_mode_e;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_READY  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_SEEK   = 3'd3,
        ST_WAIT   = 3'd4,
        ST_LOCK   = 3'd5
    } slip_state_e;

endpackage

// File: rtl/bitslip_window.sv
module bitslip_window #(
    parameter int W  = 10,
    parameter int OW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  dout
);
    localparam int PW = 2 * W;

    logic [W-1:0]  prev_q;
    logic [PW-1:0] pair;
    logic [W-1:0]  cand [W];
    logic [W-1:0]  sel;

    assign pair = {prev_q, din};

    // One candidate window per offset; offset k starts k bits below the top.
    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = pair[PW-1-k -: W];
    end

    always_comb begin
        sel = '0;
        for (int k = 0; k < W; k++) begin
            if (off == OW'(k)) sel = cand[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            dout   <= '0;
        end else begin
            prev_q <= din;
            dout   <= sel;
        end
    end

endmodule

// File: rtl/bitslip_offset.sv
module bitslip_offset #(
    parameter int W  = 10,
    parameter int OW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [OW-1:0] off_q
);
    localparam logic [OW-1:0] LAST = OW'(W - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (clr) begin
            off_q <= '0;
        end else if (inc) begin
            off_q <= (off_q == LAST) ? '0 : off_q + 1'b1;
        end else if (dec) begin
            off_q <= (off_q == '0) ? LAST : off_q - 1'b1;
        end
    end

    a_r4_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && off_q == LAST) |=> off_q == '0);

    a_r5_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr && off_q == '0) |=> off_q == LAST);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> off_q == '0);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec && !clr) |=> $stable(off_q));

endmodule

// File: rtl/bitslip_fsm.sv
module bitslip_fsm
    import bitslip_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slip_mode_e        mode,
    input  logic              req,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              match,
    output logic              inc,
    output logic              dec,
    output logic              clr,
    output logic              locked
);
    slip_state_e       state_q, state_d;
    slip_mode_e        mode_q;
    logic [WAIT_W-1:0] wcnt_q;

    // State register, mode register and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= MODE_OFF;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
            if (state_q == ST_SEEK && state_d == ST_WAIT)
                wcnt_q <= wait_cfg;
            else if (state_q == ST_WAIT && wcnt_q != '0)
                wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        inc     = 1'b0;
        dec     = 1'b0;
        clr     = 1'b0;
        locked  = (state_q == ST_LOCK);
        if (mode != mode_q) begin
            // enter: the request in this cycle is dropped
            unique case (mode)
                MODE_OFF:   state_d = ST_OFF;
                MODE_LEFT:  state_d = ST_READY;
                MODE_RIGHT: state_d = ST_READY;
                MODE_AUTO:  state_d = ST_SEEK;
                default:    state_d = ST_OFF;
            endcase
            clr = (mode == MODE_OFF);
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    clr = 1'b1;
                end
                ST_READY: begin
                    if (req) begin
                        inc     = (mode_q == MODE_LEFT);
                        dec     = (mode_q == MODE_RIGHT);
                        state_d = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    state_d = ST_READY;
                end
                ST_SEEK: begin
                    if (match) begin
                        state_d = ST_LOCK;
                    end else begin
                        inc     = 1'b1;
                        state_d = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wcnt_q == '0) state_d = ST_SEEK;
                end
                ST_LOCK: begin
                    state_d = ST_LOCK;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    a_r6_settle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> !(inc || dec));

    a_r8_auto_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_AUTO && mode == MODE_AUTO && state_q != ST_SEEK) |-> !(inc || dec));

    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && mode == mode_q) |=> state_q == ST_LOCK);

    a_r8_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && wcnt_q != '0 && mode == mode_q) |=> state_q == ST_WAIT);

    a_r2_off_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> !(inc || dec));

endmodule

// File: rtl/rx_bitslip_aligner.sv
module rx_bitslip_aligner
    import bitslip_pkg::*;
#(
    parameter int W      = 10,
    parameter int WAIT_W = 4,
    localparam int OW    = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      rx_word,
    input  logic              slide_pulse,
    input  logic [1:0]        slide_mode,
    input  logic [WAIT_W-1:0] seek_wait,
    input  logic [W-1:0]      seek_pattern,
    output logic [W-1:0]      aligned_word,
    output logic [OW-1:0]     bit_offset,
    output logic              seek_locked
);
    logic inc, dec, clr, match;

    assign match = (aligned_word == seek_pattern);

    bitslip_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (slip_mode_e'(slide_mode)),
        .req      (slide_pulse),
        .wait_cfg (seek_wait),
        .match    (match),
        .inc      (inc),
        .dec      (dec),
        .clr      (clr),
        .locked   (seek_locked)
    );

    bitslip_offset #(.W(W), .OW(OW)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .dec   (dec),
        .clr   (clr),
        .off_q (bit_offset)
    );

    bitslip_window #(.W(W), .OW(OW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_word),
        .off   (bit_offset),
        .dout  (aligned_word)
    );

    a_r9_lock_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (slide_mode != 2'b11) |=> !seek_locked);

endmodule

// File: tb/tb_rx_bitslip_aligner.sv
module tb_rx_bitslip_aligner;
    localparam int W  = 10;
    localparam int OW = $clog2(W);

    typedef struct {
        logic [W-1:0]  word;
        logic [OW-1:0] off;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  rx_word = '0;
    logic          slide_pulse = 1'b0;
    logic [1:0]    slide_mode = 2'b00;
    logic [3:0]    seek_wait = 4'd7;
    logic [W-1:0]  seek_pattern = '0;
    logic [W-1:0]  aligned_word;
    logic [OW-1:0] bit_offset;
    logic          seek_locked;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    exp_t q[$];

    logic [W-1:0]  m_prev = '0;
    int            m_off = 0;
    logic [1:0]    m_mode = 2'b00;
    bit            m_settle = 0;

    rx_bitslip_aligner #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .slide_pulse(slide_pulse),
        .slide_mode(slide_mode), .seek_wait(seek_wait), .seek_pattern(seek_pattern),
        .aligned_word(aligned_word), .bit_offset(bit_offset), .seek_locked(seek_locked)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [W-1:0] window(logic [W-1:0] p, logic [W-1:0] c, int k);
        logic [2*W-1:0] pr;
        pr = {p, c};
        return pr[2*W-1-k -: W];
    endfunction

    function automatic logic [W-1:0] rotl(logic [W-1:0] v, int n);
        return window(v, v, n);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Driver: drives one cycle, predicts and queues the result of the next edge.
    task automatic step(logic [W-1:0] d, logic rq, logic [1:0] md, string tag);
        exp_t e;
        bit known;
        @(negedge clk);
        rx_word = d; slide_pulse = rq; slide_mode = md;
        known = (m_mode != 2'b11);
        e.word = window(m_prev, d, m_off);
        if (md != m_mode) begin
            m_mode = md; m_settle = 0;
            if (md == 2'b00) m_off = 0;
        end else if (m_settle) begin
            m_settle = 0;
        end else if (rq && md == 2'b01) begin
            m_off = (m_off + 1) % W; m_settle = 1;
        end else if (rq && md == 2'b10) begin
            m_off = (m_off + W - 1) % W; m_settle = 1;
        end
        m_prev = d;
        e.off = OW'(m_off);
        e.tag = tag;
        if (known && md != 2'b11) q.push_back(e);
    endtask

    // Monitor: compares each produced word against the scoreboard.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " word"}, 32'(aligned_word), 32'(e.word));
            check({e.tag, " offset"}, 32'(bit_offset), 32'(e.off));
            check({e.tag, " locked"}, 32'(seek_locked), 32'd0);
        end
    end

    task automatic sample();
        @(posedge clk); #2;
    endtask

    localparam logic [W-1:0] D = 10'b0011111010;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", 32'(aligned_word), 0);
        check("R1 reset offset", 32'(bit_offset), 0);
        check("R1 reset locked", 32'(seek_locked), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: off mode, pulses ignored
        for (int i = 0; i < 12; i++) step(W'(i * 37 + 5), i[0], 2'b00, "R2");
        // R7: change to left with a pulse in the same cycle (dropped)
        step(10'h155, 1'b1, 2'b01, "R7");
        // R4: spaced pulses across the wrap
        for (int i = 0; i < 24; i++) step(W'(i * 91 + 3), ~i[0], 2'b01, "R4");
        // R6: pulses on consecutive cycles
        for (int i = 0; i < 6; i++) step(W'(i * 53 + 9), 1'b1, 2'b01, "R6");
        // R5: right mode, across the wrap below 0
        step(10'h2aa, 1'b0, 2'b10, "R7");
        for (int i = 0; i < 30; i++) step(W'(i * 29 + 11), ~i[0], 2'b10, "R5");
        // R3: window at varied data patterns
        for (int i = 0; i < 10; i++) step(W'(i * 113 + 7), 1'b0, 2'b10, "R3");
        // R7: back to off clears offset
        step(10'h0f0, 1'b1, 2'b00, "R7");
        for (int i = 0; i < 4; i++) step(D, 1'b0, 2'b00, "R2");
        sample();

        // R8/R10: auto search with wait 7, pattern at offset 3
        seek_wait = 4'd7;
        seek_pattern = rotl(D, 3);
        for (int i = 0; i < 28; i++) step(D, 1'b0, 2'b11, "R8");
        sample();
        check("R10 not yet locked (wait 7)", 32'(seek_locked), 0);
        step(D, 1'b0, 2'b11, "R8");
        sample();
        check("R10 locked (wait 7)", 32'(seek_locked), 1);
        check("R8 offset found", 32'(bit_offset), 3);
        check("R9 word matches pattern", 32'(aligned_word), 32'(rotl(D, 3)));
        // R8/R9: pulses ignored once locked
        for (int i = 0; i < 5; i++) step(D, 1'b1, 2'b11, "R8");
        sample();
        check("R8 pulses ignored", 32'(bit_offset), 3);
        check("R9 lock held", 32'(seek_locked), 1);

        // R7: leave auto to off, lock drops and offset clears
        step(D, 1'b0, 2'b00, "R7");
        sample();
        check("R9 lock cleared on mode change", 32'(seek_locked), 0);
        check("R7 offset cleared", 32'(bit_offset), 0);
        for (int i = 0; i < 3; i++) step(D, 1'b0, 2'b00, "R2");

        // R10: auto search with wait 0
        seek_wait = 4'd0;
        for (int i = 0; i < 7; i++) step(D, 1'b0, 2'b11, "R10");
        sample();
        check("R10 not yet locked (wait 0)", 32'(seek_locked), 0);
        step(D, 1'b0, 2'b11, "R10");
        sample();
        check("R10 locked (wait 0)", 32'(seek_locked), 1);
        check("R10 offset (wait 0)", 32'(bit_offset), 3);

        step(D, 1'b0, 2'b00, "R7");
        for (int i = 0; i < 3; i++) step(W'(i * 7 + 1), 1'b1, 2'b00, "R2");
        repeat (3) @(posedge clk);
        #7;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule